// File: doc/BRIEF.md
# GPIO Interrupt Cause Aggregator

This block collects interrupt requests from 32 general-purpose input lines and reduces them to four summary requests for a main interrupt controller. Each line is brought into the clock domain by a two-flop synchronizer. It is then optionally inverted by a per-pin polarity bit, which gives the pin's data-in value. Two sources are derived from data-in. The level source is data-in itself. The edge source is a sticky bit that records each low-to-high transition of data-in. Each source has its own enable mask, and the two masked sources are ORed per pin. The pin results are then ORed in groups of eight, and each group drives one registered summary output.

Software controls the block through a small word-addressed register port. A request is a single cycle with `bus_valid` high. Writes take effect at that clock edge. Read data and `bus_rvalid` appear one clock later. The port is driven by a two-state sequencer. `BUS_IDLE` moves to `BUS_RESP` when a read request is seen. `BUS_RESP` returns to `BUS_IDLE` unless another read arrives, in which case it stays in `BUS_RESP`. A write or an empty cycle always leads to `BUS_IDLE`.

A pin takes part in interrupts only when its direction bit marks it as an input. Because polarity is applied before the edge detector, one rising detector covers both edge senses. Software may also flip a pin's polarity at run time to catch the opposite edge next.

Top module: `gpio_irq_aggr`

## Requirements
- R1: The data-in value of pin i is the line, delayed by two synchronizer flops, XOR polarity bit i. Data-in is readable at byte offset 0x4. Polarity is at offset 0x8, and 1 inverts the pin.
- R2: With level-mask bit i (offset 0x14) set and pin i an input, data-in of 1 raises the pin's cause. Nothing is latched, so the cause drops when data-in returns to 0.
- R3: A 0-to-1 change of data-in on an input pin sets edge-cause bit i (offset 0xC). The bit stays set after data-in falls. It reaches the summary output only while edge-mask bit i (offset 0x10) is 1.
- R4: With polarity bit i set to 1, a high-to-low change on the line sets edge-cause bit i.
- R5: A pin whose direction bit (offset 0x0) is 0 is an output. Such a pin never sets its edge-cause bit and never contributes level cause.
- R6: Writing edge-cause clears each bit whose written value is 0 and leaves each bit whose written value is 1 unchanged.
- R7: If an edge sets bit i in the same cycle as a write that clears bit i, the bit ends set.
- R8: A polarity write that turns data-in from 0 to 1 counts as a rising edge and sets the edge-cause bit.
- R9: Summary output g is the OR of the combined causes of pins 8g to 8g+7. It is registered and appears one clock after the cause.
- R10: After reset the direction, polarity, level-mask, edge-mask and edge-cause registers and the summary outputs are all zero.
- R11: Read data and `bus_rvalid` are valid in the cycle after a read request. Writes to offset 0x4 are ignored. Unmapped or misaligned offsets read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_in | input | 32 | Raw asynchronous GPIO lines |
| bus_valid | input | 1 | Register access request, one cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one clock after a read |
| irq_group | output | 4 | Registered summary interrupt per group of eight pins |

## Verification
The hardest case is a new edge landing in exactly the cycle in which software clears the same edge-cause bit. A line edge only reaches the detector after two synchronizer stages, so it is hard to align from outside. The bench therefore creates the edge with a polarity write. That write changes data-in at once, so the rising condition is present at the very next clock. The bench issues the clearing write to edge-cause on that next clock, back to back with the polarity write. It then checks that the targeted bit survived while a neighbouring bit, cleared by the same write with no new edge, was cleared.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    // Word index (byte offset / 4) of each register
    typedef enum logic [2:0] {
        SEL_CONF  = 3'd0,
        SEL_DIN   = 3'd1,
        SEL_POL   = 3'd2,
        SEL_CAUSE = 3'd3,
        SEL_EMASK = 3'd4,
        SEL_LMASK = 3'd5
    } reg_sel_e;

    typedef enum logic {
        BUS_IDLE = 1'b0,
        BUS_RESP = 1'b1
    } bus_state_e;

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] meta_q;
    logic [WIDTH-1:0] stab_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            stab_q <= '0;
        end else begin
            meta_q <= d;
            stab_q <= meta_q;
        end
    end

    assign q = stab_q;
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_irq_pkg::*;
#(
    parameter int NUM_LINES = 32,
    parameter int ADDR_W    = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_valid,
    input  logic                 bus_write,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [NUM_LINES-1:0] bus_wdata,
    output logic [NUM_LINES-1:0] bus_rdata,
    output logic                 bus_rvalid,
    input  logic [NUM_LINES-1:0] data_in,
    input  logic [NUM_LINES-1:0] edge_cause,
    output logic [NUM_LINES-1:0] io_conf,
    output logic [NUM_LINES-1:0] polarity,
    output logic [NUM_LINES-1:0] edge_mask,
    output logic [NUM_LINES-1:0] level_mask,
    output logic                 cause_wr_en,
    output logic [NUM_LINES-1:0] cause_wr_data
);
    localparam int IDX_W = ADDR_W - 2;

    bus_state_e           state_q, state_d;
    logic                 aligned;
    logic [IDX_W-1:0]     idx;
    logic                 wr_req, rd_req;
    logic [NUM_LINES-1:0] rd_mux;
    logic [NUM_LINES-1:0] rdata_q;

    assign aligned = (bus_addr[1:0] == 2'b00);
    assign idx     = bus_addr[ADDR_W-1:2];
    assign wr_req  = bus_valid &&  bus_write && aligned;
    assign rd_req  = bus_valid && !bus_write;

    // Sequencer: state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= BUS_IDLE;
        else        state_q <= state_d;
    end

    // Sequencer: next state
    always_comb begin
        unique case (state_q)
            BUS_IDLE: state_d = rd_req ? BUS_RESP : BUS_IDLE;
            BUS_RESP: state_d = rd_req ? BUS_RESP : BUS_IDLE;
            default:  state_d = BUS_IDLE;
        endcase
    end

    // Sequencer: outputs
    always_comb begin
        unique case (state_q)
            BUS_IDLE: bus_rvalid = 1'b0;
            BUS_RESP: bus_rvalid = 1'b1;
            default:  bus_rvalid = 1'b0;
        endcase
    end

    // Control registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            io_conf    <= '0;
            polarity   <= '0;
            edge_mask  <= '0;
            level_mask <= '0;
        end else if (wr_req) begin
            case (idx)
                IDX_W'(SEL_CONF):  io_conf    <= bus_wdata;
                IDX_W'(SEL_POL):   polarity   <= bus_wdata;
                IDX_W'(SEL_EMASK): edge_mask  <= bus_wdata;
                IDX_W'(SEL_LMASK): level_mask <= bus_wdata;
                default: ;
            endcase
        end
    end

    assign cause_wr_en   = wr_req && (idx == IDX_W'(SEL_CAUSE));
    assign cause_wr_data = bus_wdata;

    // Read multiplexer
    always_comb begin
        rd_mux = '0;
        if (aligned) begin
            case (idx)
                IDX_W'(SEL_CONF):  rd_mux = io_conf;
                IDX_W'(SEL_DIN):   rd_mux = data_in;
                IDX_W'(SEL_POL):   rd_mux = polarity;
                IDX_W'(SEL_CAUSE): rd_mux = edge_cause;
                IDX_W'(SEL_EMASK): rd_mux = edge_mask;
                IDX_W'(SEL_LMASK): rd_mux = level_mask;
                default:           rd_mux = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      rdata_q <= '0;
        else if (rd_req) rdata_q <= rd_mux;
    end

    assign bus_rdata = rdata_q;
endmodule

// File: rtl/gpio_cause.sv
module gpio_cause #(
    parameter int NUM_LINES  = 32,
    parameter int GROUP_SIZE = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_LINES-1:0]  sync_line,
    input  logic [NUM_LINES-1:0]  polarity,
    input  logic [NUM_LINES-1:0]  io_conf,
    input  logic [NUM_LINES-1:0]  edge_mask,
    input  logic [NUM_LINES-1:0]  level_mask,
    input  logic                  cause_wr_en,
    input  logic [NUM_LINES-1:0]  cause_wr_data,
    output logic [NUM_LINES-1:0]  data_in,
    output logic [NUM_LINES-1:0]  edge_cause,
    output logic [NUM_LINES/GROUP_SIZE-1:0] irq_group
);
    localparam int NUM_GROUPS = NUM_LINES / GROUP_SIZE;

    logic [NUM_LINES-1:0]  prev_q;
    logic [NUM_LINES-1:0]  rise;
    logic [NUM_LINES-1:0]  kept;
    logic [NUM_LINES-1:0]  cause_q;
    logic [NUM_LINES-1:0]  combined;
    logic [NUM_GROUPS-1:0] grp_any;
    logic [NUM_GROUPS-1:0] irq_q;

    assign data_in = sync_line ^ polarity;
    assign rise    = data_in & ~prev_q & io_conf;
    assign kept    = cause_wr_en ? (cause_q & cause_wr_data) : cause_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q  <= '0;
            cause_q <= '0;
        end else begin
            prev_q  <= data_in;
            cause_q <= kept | rise;   // a new edge beats a clearing write
        end
    end

    assign edge_cause = cause_q;
    assign combined   = (data_in & level_mask & io_conf) | (cause_q & edge_mask);

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
        assign grp_any[g] = |combined[g*GROUP_SIZE +: GROUP_SIZE];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_q <= '0;
        else        irq_q <= grp_any;
    end

    assign irq_group = irq_q;
endmodule

// File: rtl/gpio_irq_aggr.sv
module gpio_irq_aggr
    import gpio_irq_pkg::*;
#(
    parameter int NUM_LINES  = 32,
    parameter int GROUP_SIZE = 8,
    parameter int ADDR_W     = 5
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [NUM_LINES-1:0]            line_in,
    input  logic                            bus_valid,
    input  logic                            bus_write,
    input  logic [ADDR_W-1:0]               bus_addr,
    input  logic [NUM_LINES-1:0]            bus_wdata,
    output logic [NUM_LINES-1:0]            bus_rdata,
    output logic                            bus_rvalid,
    output logic [NUM_LINES/GROUP_SIZE-1:0] irq_group
);
    logic [NUM_LINES-1:0] sync_line;
    logic [NUM_LINES-1:0] data_in_w;
    logic [NUM_LINES-1:0] edge_cause_w;
    logic [NUM_LINES-1:0] io_conf_w;
    logic [NUM_LINES-1:0] polarity_w;
    logic [NUM_LINES-1:0] edge_mask_w;
    logic [NUM_LINES-1:0] level_mask_w;
    logic                 cause_wr_en;
    logic [NUM_LINES-1:0] cause_wr_data;

    gpio_sync #(.WIDTH(NUM_LINES)) u_sync (
        .clk (clk),
        .rst_n (rst_n),
        .d (line_in),
        .q (sync_line)
    );

    gpio_regs #(.NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W)) u_regs (
        .clk (clk),
        .rst_n (rst_n),
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .bus_addr (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .bus_rvalid (bus_rvalid),
        .data_in (data_in_w),
        .edge_cause (edge_cause_w),
        .io_conf (io_conf_w),
        .polarity (polarity_w),
        .edge_mask (edge_mask_w),
        .level_mask (level_mask_w),
        .cause_wr_en (cause_wr_en),
        .cause_wr_data (cause_wr_data)
    );

    gpio_cause #(.NUM_LINES(NUM_LINES), .GROUP_SIZE(GROUP_SIZE)) u_cause (
        .clk (clk),
        .rst_n (rst_n),
        .sync_line (sync_line),
        .polarity (polarity_w),
        .io_conf (io_conf_w),
        .edge_mask (edge_mask_w),
        .level_mask (level_mask_w),
        .cause_wr_en (cause_wr_en),
        .cause_wr_data (cause_wr_data),
        .data_in (data_in_w),
        .edge_cause (edge_cause_w),
        .irq_group (irq_group)
    );
endmodule

// File: rtl/gpio_irq_chk.sv
module gpio_irq_chk #(
    parameter int NUM_LINES  = 32,
    parameter int GROUP_SIZE = 8
) (
    input logic                            clk,
    input logic                            rst_n,
    input logic                            bus_valid,
    input logic                            bus_write,
    input logic                            bus_rvalid,
    input logic                            cause_wr_en,
    input logic [NUM_LINES-1:0]            io_conf,
    input logic [NUM_LINES-1:0]            polarity,
    input logic [NUM_LINES-1:0]            data_in,
    input logic [NUM_LINES-1:0]            edge_cause,
    input logic [NUM_LINES-1:0]            edge_mask,
    input logic [NUM_LINES-1:0]            level_mask,
    input logic [NUM_LINES/GROUP_SIZE-1:0] irq_group
);
    localparam int NUM_GROUPS = NUM_LINES / GROUP_SIZE;

    logic [NUM_LINES-1:0]  pin_req;
    logic [NUM_GROUPS-1:0] grp_req;

    assign pin_req = (data_in & level_mask & io_conf) | (edge_cause & edge_mask);
    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_req
        assign grp_req[g] = |pin_req[g*GROUP_SIZE +: GROUP_SIZE];
    end

    // R9: summary follows the group cause one clock later
    assert_group_summary_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_group == $past(grp_req));

    // R5: no edge-cause bit rises on a pin configured as output
    assert_no_set_on_output_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_cause & ~$past(edge_cause) & ~$past(io_conf)) == '0);

    // R6: without a write to edge-cause, no bit ever clears
    assert_cause_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !cause_wr_en |=> (($past(edge_cause) & ~edge_cause) == '0));

    // R10: leaving reset, control and cause state are zero
    assert_reset_state_R10: assert property (@(posedge clk)
        $rose(rst_n) |-> (edge_cause == '0 && edge_mask == '0 && level_mask == '0
                          && io_conf == '0 && polarity == '0 && irq_group == '0));

    // R11: a read is answered in the next cycle, nothing else raises valid
    assert_read_resp_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_write) |=> bus_rvalid);
    assert_no_spurious_resp_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_valid && !bus_write) |=> !bus_rvalid);
endmodule

bind gpio_irq_aggr gpio_irq_chk #(.NUM_LINES(NUM_LINES), .GROUP_SIZE(GROUP_SIZE)) u_chk (
    .clk (clk),
    .rst_n (rst_n),
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_rvalid (bus_rvalid),
    .cause_wr_en (cause_wr_en),
    .io_conf (io_conf_w),
    .polarity (polarity_w),
    .data_in (data_in_w),
    .edge_cause (edge_cause_w),
    .edge_mask (edge_mask_w),
    .level_mask (level_mask_w),
    .irq_group (irq_group)
);

// File: tb/sim_gpio_irq_aggr.sv
module sim_gpio_irq_aggr;
    localparam logic [4:0] A_CONF  = 5'h00;
    localparam logic [4:0] A_DIN   = 5'h04;
    localparam logic [4:0] A_POL   = 5'h08;
    localparam logic [4:0] A_CAUSE = 5'h0C;
    localparam logic [4:0] A_EMASK = 5'h10;
    localparam logic [4:0] A_LMASK = 5'h14;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] line_in = '0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_rvalid;
    logic [3:0]  irq_group;

    int n_run  = 0;
    int n_fail = 0;
    logic last_rvalid;

    always #2 clk = ~clk;

    gpio_irq_aggr u0 (
        .clk (clk), .rst_n (rst_n), .line_in (line_in),
        .bus_valid (bus_valid), .bus_write (bus_write), .bus_addr (bus_addr),
        .bus_wdata (bus_wdata), .bus_rdata (bus_rdata), .bus_rvalid (bus_rvalid),
        .irq_group (irq_group)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_valid = 1'b0;
        d = bus_rdata;
        last_rvalid = bus_rvalid;
    endtask

    task automatic settle();
        repeat (5) @(negedge clk);
    endtask

    task automatic clear_all();
        wr(A_LMASK, '0);
        wr(A_EMASK, '0);
        wr(A_POL, '0);
        line_in = '0;
        settle();
        wr(A_CONF, 32'hFFFF_FFFF);
        wr(A_CAUSE, '0);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        check(irq_group == 4'h0, "R10 irq after reset", {28'h0, irq_group}, 32'h0);
        rd(A_LMASK, v); check(v == 0, "R10 level mask", v, 0);
        check(last_rvalid == 1'b1, "R11 rvalid after read", {31'h0, last_rvalid}, 32'h1);
        rd(A_EMASK, v); check(v == 0, "R10 edge mask", v, 0);
        rd(A_CAUSE, v); check(v == 0, "R10 edge cause", v, 0);
        rd(A_CONF, v);  check(v == 0, "R10 direction", v, 0);
        rd(A_POL, v);   check(v == 0, "R10 polarity", v, 0);
    endtask

    task automatic t_datain();
        logic [31:0] v;
        clear_all();
        line_in = 32'h1234_A5C3;
        wr(A_POL, 32'h0F0F_00FF);
        settle();
        rd(A_DIN, v);
        check(v == (32'h1234_A5C3 ^ 32'h0F0F_00FF), "R1 data-in xor polarity", v, 32'h1234_A5C3 ^ 32'h0F0F_00FF);
        wr(A_DIN, 32'h0);
        rd(A_DIN, v);
        check(v == (32'h1234_A5C3 ^ 32'h0F0F_00FF), "R11 data-in write ignored", v, 32'h1234_A5C3 ^ 32'h0F0F_00FF);
        rd(5'h18, v); check(v == 0, "R11 unmapped reads zero", v, 0);
        rd(5'h09, v); check(v == 0, "R11 misaligned reads zero", v, 0);
    endtask

    task automatic t_level();
        clear_all();
        wr(A_LMASK, 32'h0000_0200);
        @(negedge clk); line_in[9] = 1'b1;
        repeat (2) @(negedge clk);
        check(irq_group == 4'h0, "R9 level not yet visible", {28'h0, irq_group}, 0);
        @(negedge clk);
        check(irq_group == 4'b0010, "R2 level high pin 9 to group 1", {28'h0, irq_group}, 32'h2);
        line_in[9] = 1'b0;
        settle();
        check(irq_group == 4'h0, "R2 level not latched", {28'h0, irq_group}, 0);
        wr(A_POL, 32'h0010_0000);
        wr(A_LMASK, 32'h0010_0000);
        settle();
        check(irq_group == 4'b0100, "R2 active-low level pin 20", {28'h0, irq_group}, 32'h4);
    endtask

    task automatic t_rise();
        logic [31:0] v;
        clear_all();
        @(negedge clk); line_in[30] = 1'b1;
        settle();
        rd(A_CAUSE, v); check(v == 32'h4000_0000, "R3 rising sets cause", v, 32'h4000_0000);
        check(irq_group == 4'h0, "R3 masked edge no irq", {28'h0, irq_group}, 0);
        line_in[30] = 1'b0;
        wr(A_EMASK, 32'h4000_0000);
        settle();
        check(irq_group == 4'b1000, "R3 sticky cause reaches group 3", {28'h0, irq_group}, 32'h8);
        wr(A_CAUSE, 32'hBFFF_FFFF);
        rd(A_CAUSE, v); check(v == 0, "R6 write zero clears", v, 0);
        wr(A_CAUSE, 32'hFFFF_FFFF);
        rd(A_CAUSE, v); check(v == 0, "R6 write one no effect", v, 0);
        check(irq_group == 4'h0, "R9 group drops after clear", {28'h0, irq_group}, 0);
    endtask

    task automatic t_fall();
        logic [31:0] v;
        clear_all();
        line_in[12] = 1'b1;
        settle();
        wr(A_POL, 32'h0000_1000);
        settle();
        wr(A_CAUSE, '0);
        line_in[12] = 1'b0;
        settle();
        rd(A_CAUSE, v); check(v == 32'h0000_1000, "R4 falling with polarity 1", v, 32'h0000_1000);
    endtask

    task automatic t_outpin();
        logic [31:0] v;
        clear_all();
        wr(A_CONF, 32'hFFFF_FFDF);
        wr(A_LMASK, 32'h0000_0020);
        wr(A_EMASK, 32'h0000_0020);
        line_in[5] = 1'b1;
        settle();
        check(irq_group == 4'h0, "R5 output pin no irq", {28'h0, irq_group}, 0);
        rd(A_CAUSE, v); check(v == 0, "R5 output pin no edge cause", v, 0);
    endtask

    task automatic t_poltoggle();
        logic [31:0] v;
        clear_all();
        wr(A_POL, 32'h0002_0000);
        settle();
        rd(A_CAUSE, v); check(v == 32'h0002_0000, "R8 polarity flip is rising", v, 32'h0002_0000);
    endtask

    task automatic t_setwins();
        logic [31:0] v;
        clear_all();
        wr(A_POL, 32'h0000_000C);
        settle();
        rd(A_CAUSE, v); check(v == 32'h0000_000C, "R8 two causes set", v, 32'h0000_000C);
        wr(A_POL, 32'h0);
        settle();
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = A_POL; bus_wdata = 32'h0000_0004;
        @(negedge clk);
        bus_addr = A_CAUSE; bus_wdata = 32'h0;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
        rd(A_CAUSE, v); check(v == 32'h0000_0004, "R7 set wins over clear", v, 32'h0000_0004);
    endtask

    initial begin
        #400000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_datain();
        t_level();
        t_rise();
        t_fall();
        t_outpin();
        t_poltoggle();
        t_setwins();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule